// File: doc/BRIEF.md
# Up-Counting Overflow Event Timer

This block is a register-programmed event timer that counts upward, one step per clock, and raises a level interrupt when the count rolls over past all-ones. To get an event after a given interval, software loads the counter with all-ones minus the interval. In one-shot use the count rolls over to zero and keeps running. In periodic use the count is refilled from a separate reload register on each rollover, so the period is set once and then repeats.

Writes to the control, counter and reload registers are posted. They reach the counting logic a fixed number of clocks after the bus captures them. A per-register pending flag stays high for that window, so software can poll until a write has landed. The overflow status bit and the interrupt enable sit on the bus side and act at once. The status bit is cleared by writing one to it. The bus is a simple single-cycle write strobe with combinational read data.

Register map (3-bit address): 0 control (bit0 run, bit1 auto-reload), 1 counter, 2 reload, 3 overflow status (bit0), 4 interrupt enable (bit0), 5 write-pending flags (bit0 control, bit1 counter, bit2 reload). Addresses 6 and 7 read as zero.

Top module: `gp_event_timer`

## Requirements
- R1: After reset, the counter, control, reload, status, enable and pending registers all read 0, and irq is low.
- R2: A write to address 0, 1 or 2 takes effect exactly SYNC_LAT (default 3) clocks after the edge that captures it. The pending flag for that register (address 5: bit0 control, bit1 counter, bit2 reload) is high from the capturing edge until the landing edge, and low afterwards.
- R3: While run (address 0 bit0) is set, the counter rises by one on each clock. Reading address 1 returns the live count and does not change it.
- R4: On the clock edge where a running counter holds all-ones, the overflow status bit (address 3 bit0) becomes 1.
- R5: With auto-reload (address 0 bit1) clear, a rollover leaves the counter at 0 and counting continues.
- R6: With auto-reload set, a rollover loads the counter from the reload register (address 2), so a reload value of all-ones minus (P-1) gives an overflow every P clocks.
- R7: Clearing run freezes the counter at its value on the landing edge.
- R8: Writing 1 to address 3 bit0 clears the status bit on the capturing edge. Writing 0 there leaves it unchanged. Writes to addresses 3 and 4 are not posted.
- R9: irq is high exactly while the status bit and the interrupt enable (address 4 bit0) are both 1.
- R10: When a clear write and a new overflow fall on the same edge, the status bit stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| addr | input | 3 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench goes after the exact landing cycle of posted writes. A design with a latency off by one would show the new counter value, or a dropped pending flag, one check too early or too late. Each rollover is tested with and without auto-reload, including a start value at all-ones. A design that wrapped to the wrong value, or set status a cycle late, would miss the counts the bench's own model predicts. The bench places a status clear on the very edge of a second overflow, so a design that lets the clear win reads status 0 there. It also checks that writing 0 to status and leaving the enable low both keep irq in its current state.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned NTGT = 3;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_COUNT  = 3'd1,
    A_RELOAD = 3'd2,
    A_STATUS = 3'd3,
    A_IRQEN  = 3'd4,
    A_PEND   = 3'd5
  } reg_addr_e;

  localparam logic [1:0] TGT_CTRL = 2'd0;
  localparam logic [1:0] TGT_CNT  = 2'd1;
  localparam logic [1:0] TGT_RLD  = 2'd2;
endpackage

// File: rtl/gpt_post_pipe.sv
module gpt_post_pipe import gpt_pkg::*; #(
  parameter int unsigned DW  = 32,
  parameter int unsigned LAT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_tgt,
  input  logic [DW-1:0]   in_data,
  output logic            land_valid,
  output logic [1:0]      land_tgt,
  output logic [DW-1:0]   land_data,
  output logic [NTGT-1:0] pending
);
  logic [LAT-1:0] st_v;
  logic [1:0]     st_t [LAT];
  logic [DW-1:0]  st_d [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v <= '0;
      for (int i = 0; i < LAT; i++) begin
        st_t[i] <= '0;
        st_d[i] <= '0;
      end
    end else begin
      st_v[0] <= in_valid;
      st_t[0] <= in_tgt;
      st_d[0] <= in_data;
      for (int i = 1; i < LAT; i++) begin
        st_v[i] <= st_v[i-1];
        st_t[i] <= st_t[i-1];
        st_d[i] <= st_d[i-1];
      end
    end
  end

  always_comb begin
    pending = '0;
    for (int i = 0; i < LAT; i++) begin
      for (int t = 0; t < int'(NTGT); t++) begin
        if (st_v[i] && (st_t[i] == 2'(t))) pending[t] = 1'b1;
      end
    end
  end

  assign land_valid = st_v[LAT-1];
  assign land_tgt   = st_t[LAT-1];
  assign land_data  = st_d[LAT-1];

  // R2
  wr_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (pending != '0));
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core import gpt_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          land_valid,
  input  logic [1:0]    land_tgt,
  input  logic [DW-1:0] land_data,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] reload,
  output logic          run,
  output logic          autoreload,
  output logic          ovf_evt
);
  function automatic logic at_top(input logic [DW-1:0] v);
    return &v;
  endfunction

  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] v,
                                               input logic ar,
                                               input logic [DW-1:0] rl);
    if (at_top(v)) return ar ? rl : '0;
    return v + DW'(1);
  endfunction

  logic ld_ctrl, ld_cnt, ld_rld;
  assign ld_ctrl = land_valid && (land_tgt == TGT_CTRL);
  assign ld_cnt  = land_valid && (land_tgt == TGT_CNT);
  assign ld_rld  = land_valid && (land_tgt == TGT_RLD);
  assign ovf_evt = run && at_top(cnt) && !ld_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      reload     <= '0;
      run        <= 1'b0;
      autoreload <= 1'b0;
    end else begin
      if (ld_ctrl) begin
        run        <= land_data[0];
        autoreload <= land_data[1];
      end
      if (ld_rld) reload <= land_data;
      if (ld_cnt) cnt <= land_data;
      else if (run) cnt <= next_count(cnt, autoreload, reload);
    end
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(&cnt) && !ld_cnt) |=> (cnt == $past(cnt) + DW'(1)));
  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_cnt) |=> $stable(cnt));
  // R6
  reload_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && autoreload && !ld_rld) |=> (cnt == reload));
  // R5
  zero_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !autoreload) |=> (cnt == '0));
endmodule

// File: rtl/gpt_irq_ctrl.sv
module gpt_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic clr_req,
  input  logic en_wr,
  input  logic en_val,
  output logic status,
  output logic irq_en,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (ovf_evt)      status <= 1'b1;
      else if (clr_req) status <= 1'b0;
      if (en_wr) irq_en <= en_val;
    end
  end

  assign irq = status & irq_en;

  // R4
  ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> status);
  // R10
  clr_lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && clr_req) |=> status);
  // R8
  clr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !ovf_evt) |=> !status);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !en_val) |=> !irq);
endmodule

// File: rtl/gp_event_timer.sv
module gp_event_timer import gpt_pkg::*; #(
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 3,
  parameter int unsigned SYNC_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic            post_wr;
  logic [1:0]      post_tgt;
  logic            land_valid;
  logic [1:0]      land_tgt;
  logic [DW-1:0]   land_data;
  logic [NTGT-1:0] pending;
  logic [DW-1:0]   cnt, reload;
  logic            run, autoreload, ovf_evt;
  logic            status, irq_en, clr_req, en_wr;

  always_comb begin
    post_wr  = 1'b0;
    post_tgt = TGT_CTRL;
    if (wr_en) begin
      case (addr)
        A_CTRL:   begin post_wr = 1'b1; post_tgt = TGT_CTRL; end
        A_COUNT:  begin post_wr = 1'b1; post_tgt = TGT_CNT;  end
        A_RELOAD: begin post_wr = 1'b1; post_tgt = TGT_RLD;  end
        default:  ;
      endcase
    end
  end

  assign clr_req = wr_en && (addr == A_STATUS) && wdata[0];
  assign en_wr   = wr_en && (addr == A_IRQEN);

  gpt_post_pipe #(.DW(DW), .LAT(SYNC_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(post_wr), .in_tgt(post_tgt), .in_data(wdata),
    .land_valid(land_valid), .land_tgt(land_tgt), .land_data(land_data),
    .pending(pending)
  );

  gpt_count_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .land_valid(land_valid), .land_tgt(land_tgt), .land_data(land_data),
    .cnt(cnt), .reload(reload), .run(run), .autoreload(autoreload),
    .ovf_evt(ovf_evt)
  );

  gpt_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n),
    .ovf_evt(ovf_evt), .clr_req(clr_req),
    .en_wr(en_wr), .en_val(wdata[0]),
    .status(status), .irq_en(irq_en), .irq(irq)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[1:0] = {autoreload, run};
      A_COUNT:  rdata = cnt;
      A_RELOAD: rdata = reload;
      A_STATUS: rdata[0] = status;
      A_IRQEN:  rdata[0] = irq_en;
      A_PEND:   rdata[NTGT-1:0] = pending;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: tb/gp_event_timer_tb.sv
module gp_event_timer_tb;
  localparam logic [31:0] MAXV = 32'hFFFF_FFFF;
  localparam int NV = 6;
  localparam logic [31:0] V_START [NV] = '{32'h0, MAXV-4, MAXV-4, MAXV-2, MAXV, 32'h1234};
  localparam logic        V_AR    [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [31:0] V_RLD   [NV] = '{32'h0, 32'h0, 32'h0, MAXV-3, 32'h100, 32'h0};
  localparam int          V_STEPS [NV] = '{5, 5, 8, 6, 1, 10};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gp_event_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                        .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic setup(input logic [31:0] start, input logic ar, input logic [31:0] rl);
    do_write(3'd0, 32'd0);
    repeat (3) @(negedge clk);
    do_write(3'd3, 32'd1);
    do_write(3'd1, start);
    do_write(3'd2, rl);
    do_write(3'd0, {30'd0, ar, 1'b1});
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [32:0] model(input logic [31:0] s, input logic ar,
                                        input logic [31:0] rl, input int n);
    logic [31:0] c = s;
    logic st = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (c == MAXV) begin
        st = 1'b1;
        c = ar ? rl : 32'd0;
      end else c = c + 32'd1;
    end
    return {st, c};
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    logic [32:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 32'd0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 posted counter write lands after 3 clocks
    do_write(3'd1, 32'h55);
    rd(3'd5, v); chk("R2 pending early", v, 32'd2);
    rd(3'd1, v); chk("R2 count not yet", v, 32'd0);
    @(negedge clk);
    @(negedge clk);
    rd(3'd5, v); chk("R2 pending late", v, 32'd2);
    rd(3'd1, v); chk("R2 count still old", v, 32'd0);
    @(negedge clk);
    rd(3'd5, v); chk("R2 pending cleared", v, 32'd0);
    rd(3'd1, v); chk("R2 count landed", v, 32'h55);

    // R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      setup(V_START[i], V_AR[i], V_RLD[i]);
      repeat (V_STEPS[i]) @(negedge clk);
      m = model(V_START[i], V_AR[i], V_RLD[i], V_STEPS[i]);
      rd(3'd1, v); chk("R5/R6 vector count", v, m[31:0]);
      rd(3'd3, v); chk("R4 vector status", v, {31'd0, m[32]});
    end

    // R3 live read
    setup(32'h10, 1'b0, 32'd0);
    rd(3'd1, v); chk("R3 live read", v, 32'h10);
    rd(3'd1, v); chk("R3 reread same", v, 32'h10);
    @(negedge clk);
    rd(3'd1, v); chk("R3 next count", v, 32'h11);

    // R7 stop freezes
    do_write(3'd0, 32'd0);
    repeat (3) @(negedge clk);
    rd(3'd1, v);
    chk("R7 stopped value", v, 32'h11 + 32'd4);
    repeat (5) @(negedge clk);
    rd(3'd1, v2); chk("R7 frozen", v2, v);

    // R8 R9 status and irq gating
    setup(MAXV-1, 1'b0, 32'd0);
    repeat (3) @(negedge clk);
    rd(3'd3, v); chk("R4 one-shot status", v, 32'd1);
    chk("R9 irq off without enable", {31'd0, irq}, 32'd0);
    do_write(3'd3, 32'd0);
    rd(3'd3, v); chk("R8 write zero keeps", v, 32'd1);
    do_write(3'd4, 32'd1);
    chk("R9 irq on", {31'd0, irq}, 32'd1);
    do_write(3'd3, 32'd1);
    rd(3'd3, v); chk("R8 w1c clears", v, 32'd0);
    chk("R9 irq drops", {31'd0, irq}, 32'd0);
    do_write(3'd4, 32'd0);

    // R10 clear collides with overflow (period 4)
    setup(MAXV-3, 1'b1, MAXV-3);
    repeat (5) @(negedge clk);
    rd(3'd3, v); chk("R6 periodic status", v, 32'd1);
    do_write(3'd3, 32'd1);
    rd(3'd3, v); chk("R8 clear between events", v, 32'd0);
    @(negedge clk);
    do_write(3'd3, 32'd1);
    rd(3'd3, v); chk("R10 overflow wins", v, 32'd1);
    rd(3'd1, v); chk("R6 reload after wrap", v, MAXV-3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule